// File: doc/BRIEF.md
# SD Card Bus Clock Generator

This block derives the card-side bus clock from a fast kernel clock and produces the enables that tell the command and data launch registers when to move. A configuration register sets the divide factor, power saving, bus width, a launch-edge select and double-rate signalling. The register takes a write only while neither the command path nor the data path reports activity. Any accepted write restarts the divider from a low phase.

A divide factor N above zero gives a card clock whose high and low halves each last N kernel cycles. A divide factor of zero passes the kernel clock through, behind a glitch-free gate. With power saving on, the clock stops low while the sampled bus-idle input is high, and it restarts with a full low half. The launch strobes are one kernel cycle wide. The command strobe marks each card clock falling transition. In double-rate mode the data strobe also marks each rising transition. A level output tells the launch registers whether to capture the strobe on the kernel falling edge instead of the rising edge.

The divider is a three-state machine. LOW holds the clock low and counts N cycles. At the end of LOW it goes to HIGH (rise), or to PARK (stopped) when power saving and idle are both active. HIGH counts N cycles and then returns to LOW (fall). PARK goes to LOW (resume) once the stop condition clears. An accepted write forces LOW from any state. In bypass mode the machine rests in LOW.

Top module: `sdclk_gen`

## Requirements
- R1: With divide factor N>0, the card clock has a period of 2N kernel cycles, with N high and N low, and every transition follows a kernel rising edge. After reset or an accepted write it starts at the beginning of a low half.
- R2: With N=0, the card clock equals the kernel clock while running. Its enable is taken one cycle late through a falling-edge register, so the card clock is high in the kernel high phase of every cycle that follows a running cycle.
- R3: A write while both busy inputs are low loads the register. The read port shows it with divide factor in bits [9:0], power save at bit 10, bus width code at bits [12:11], launch-edge select at bit 13 and double-rate enable at bit 14.
- R4: A write while cmd_busy or dat_busy is high leaves every field unchanged.
- R5: stb_on_fall is 1 in bypass and in effective double-rate mode. Otherwise it equals the launch-edge select bit.
- R6: With power saving on, bus_idle is registered once. When the registered idle is high at the end of a low half, the clock stays low. After it clears, the clock gives a full N-cycle low half before rising. In bypass, the registered stop condition removes the clock one cycle later.
- R7: With N>0, cmd_stb is high for exactly the kernel cycle whose closing rising edge makes the card clock fall. In bypass it equals the running state of the clock.
- R8: In effective double-rate mode, dat_stb also goes high for the cycle whose closing edge makes the card clock rise. Otherwise it equals cmd_stb.
- R9: Double-rate is not effective when the width code is 00.
- R10: Double-rate with N=0 behaves as single-rate bypass.
- R11: During reset, the card clock and both strobes are low and the register holds divide factor RESET_DIV with all flags zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | DIV_W+5 | Configuration write data |
| cfg_rdata | output | DIV_W+5 | Current configuration |
| cmd_busy | input | 1 | Command path active, locks writes |
| dat_busy | input | 1 | Data path active, locks writes |
| bus_idle | input | 1 | Bus idle indication, kernel-clock synchronous |
| card_clk | output | 1 | Card bus clock |
| cmd_stb | output | 1 | Command launch enable |
| dat_stb | output | 1 | Data launch enable |
| stb_on_fall | output | 1 | Launch registers capture on kernel falling edge |

## Verification
The assertions assume that bus_idle, cmd_busy, dat_busy and the write port are already synchronous to the kernel clock and settle well before each rising edge. Nothing inside resynchronises them. They also assume that the configuration is not switched between bypass and divided mode while the card clock is running. The stimulus drives every input on the kernel falling edge. It changes the divide factor only through writes whose effect the reference model follows from the write cycle on. Lock tests raise the busy inputs only around write attempts.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    typedef enum logic [1:0] {
        ST_LOW  = 2'd0,
        ST_HIGH = 2'd1,
        ST_PARK = 2'd2
    } div_state_e;

    localparam int unsigned FLAG_BITS = 5;
endpackage

// File: rtl/sdclk_cfg_reg.sv
module sdclk_cfg_reg #(
    parameter int unsigned DIV_W     = 10,
    parameter int unsigned RESET_DIV = 4,
    localparam int unsigned CFG_W    = DIV_W + sdclk_pkg::FLAG_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             cmd_busy,
    input  logic             dat_busy,
    output logic             load,
    output logic [DIV_W-1:0] div,
    output logic             psave,
    output logic [1:0]       width,
    output logic             edge_sel,
    output logic             ddr,
    output logic [CFG_W-1:0] rdata
);
    localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(RESET_DIV);

    logic [CFG_W-1:0] cfg_q;

    assign load = we & ~(cmd_busy | dat_busy);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cfg_q <= CFG_RST;
        else if (load) cfg_q <= wdata;
    end

    assign div      = cfg_q[DIV_W-1:0];
    assign psave    = cfg_q[DIV_W];
    assign width    = cfg_q[DIV_W+2:DIV_W+1];
    assign edge_sel = cfg_q[DIV_W+3];
    assign ddr      = cfg_q[DIV_W+4];
    assign rdata    = cfg_q;

    // R4: locked while either path is active
    a_r4_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy || dat_busy) |=> $stable(cfg_q));
    // R3: accepted write lands in the register
    a_r3_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !cmd_busy && !dat_busy) |=> (cfg_q == $past(wdata)));
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
    import sdclk_pkg::*;
#(
    parameter int unsigned DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             load,
    input  logic             psave,
    input  logic             bus_idle,
    output logic             card_clk,
    output logic             ck_div,
    output logic             bypass,
    output logic             run_d,
    output logic             fall_next,
    output logic             rise_next
);
    div_state_e       st_q, st_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic             ck_q, idle_q, run_q, run_d_q, en_neg;
    logic             last, stop;

    assign bypass = (div == '0);
    assign last   = (cnt_q == div - 1'b1);
    assign stop   = psave & idle_q;

    // next-state process
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (load || bypass) begin
            st_d  = ST_LOW;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_LOW: begin
                    if (last) begin
                        st_d  = stop ? ST_PARK : ST_HIGH;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (last) begin
                        st_d  = ST_LOW;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_PARK: begin
                    if (!stop) begin
                        st_d  = ST_LOW;
                        cnt_d = '0;
                    end
                end
                default: begin
                    st_d  = ST_LOW;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_LOW;
            cnt_q   <= '0;
            ck_q    <= 1'b0;
            idle_q  <= 1'b0;
            run_q   <= 1'b0;
            run_d_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            ck_q    <= (st_d == ST_HIGH);
            idle_q  <= bus_idle;
            run_q   <= bypass & ~stop;
            run_d_q <= run_q;
        end
    end

    // bypass gate enable moves only while the kernel clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en_neg <= 1'b0;
        else        en_neg <= run_q;
    end

    // output process
    always_comb begin
        card_clk  = bypass ? (clk & en_neg) : ck_q;
        ck_div    = ck_q;
        run_d     = run_d_q;
        fall_next = !bypass && (st_q == ST_HIGH) && last;
        rise_next = !bypass && (st_q == ST_LOW) && last && !stop;
    end

    // R1: counter never passes the half-period length
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && st_q != ST_PARK) |-> (cnt_q < div));
    // R6: a stopped, low clock does not rise on the next edge
    a_r6_park_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && stop && !ck_q) |=> !ck_q);
    // R8: an announced rise happens unless a write restarts the divider
    a_r8_rise_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_next && !load) |=> ck_q);
endmodule

// File: rtl/sdclk_strobe.sv
module sdclk_strobe (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bypass,
    input  logic       run_d,
    input  logic       fall_next,
    input  logic       rise_next,
    input  logic       ck_div,
    input  logic       ddr,
    input  logic [1:0] width,
    input  logic       edge_sel,
    output logic       cmd_stb,
    output logic       dat_stb,
    output logic       stb_on_fall
);
    logic ddr_eff;

    always_comb begin
        ddr_eff     = ddr && (width != 2'b00) && !bypass;
        cmd_stb     = bypass ? run_d : fall_next;
        dat_stb     = bypass ? run_d : (fall_next | (ddr_eff & rise_next));
        stb_on_fall = bypass | ddr_eff | edge_sel;
    end

    // R7: a divided-mode command strobe is followed by a low card clock
    a_r7_cmd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && !bypass) |=> !ck_div);
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
    parameter int unsigned DIV_W     = 10,
    parameter int unsigned RESET_DIV = 4,
    localparam int unsigned CFG_W    = DIV_W + sdclk_pkg::FLAG_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             cmd_busy,
    input  logic             dat_busy,
    input  logic             bus_idle,
    output logic             card_clk,
    output logic             cmd_stb,
    output logic             dat_stb,
    output logic             stb_on_fall
);
    logic             load, psave, edge_sel, ddr;
    logic [1:0]       width;
    logic [DIV_W-1:0] div;
    logic             ck_div, bypass, run_d, fall_next, rise_next;

    sdclk_cfg_reg #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .cmd_busy(cmd_busy), .dat_busy(dat_busy), .load(load),
        .div(div), .psave(psave), .width(width), .edge_sel(edge_sel),
        .ddr(ddr), .rdata(cfg_rdata)
    );

    sdclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div(div), .load(load), .psave(psave),
        .bus_idle(bus_idle), .card_clk(card_clk), .ck_div(ck_div),
        .bypass(bypass), .run_d(run_d), .fall_next(fall_next),
        .rise_next(rise_next)
    );

    sdclk_strobe u_stb (
        .clk(clk), .rst_n(rst_n), .bypass(bypass), .run_d(run_d),
        .fall_next(fall_next), .rise_next(rise_next), .ck_div(ck_div),
        .ddr(ddr), .width(width), .edge_sel(edge_sel),
        .cmd_stb(cmd_stb), .dat_stb(dat_stb), .stb_on_fall(stb_on_fall)
    );
endmodule

// File: tb/tb_sdclk_gen.sv
`timescale 1ns/1ps
module tb_sdclk_gen;
    localparam int DIV_W = 10;
    localparam int RST_DIV = 4;
    localparam int CFG_W = DIV_W + 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic [CFG_W-1:0] cfg_rdata;
    logic cmd_busy = 1'b0, dat_busy = 1'b0, bus_idle = 1'b0;
    logic card_clk, cmd_stb, dat_stb, stb_on_fall;

    always #5 clk = ~clk;

    sdclk_gen #(.DIV_W(DIV_W), .RESET_DIV(RST_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cmd_busy(cmd_busy), .dat_busy(dat_busy),
        .bus_idle(bus_idle), .card_clk(card_clk), .cmd_stb(cmd_stb),
        .dat_stb(dat_stb), .stb_on_fall(stb_on_fall)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [CFG_W-1:0] pack(int d, int ps, int w, int es, int dr);
        return {dr[0], es[0], w[1:0], ps[0], d[DIV_W-1:0]};
    endfunction

    // behavioural reference model
    int m_div, m_ps, m_w, m_es, m_ddr, m_idle, m_phase, m_cnt, m_run, m_rund;

    always begin
        @(posedge clk);
        if (!rst_n) begin
            m_div = RST_DIV; m_ps = 0; m_w = 0; m_es = 0; m_ddr = 0;
            m_idle = 0; m_phase = 0; m_cnt = 0; m_run = 0; m_rund = 0;
        end else begin
            int stp;
            bit acc;
            stp = m_ps & m_idle;
            acc = cfg_we && !cmd_busy && !dat_busy;
            m_rund = m_run;
            m_run = (m_div == 0 && stp == 0) ? 1 : 0;
            if (acc) begin
                m_div = int'(cfg_wdata[DIV_W-1:0]);
                m_ps = int'(cfg_wdata[DIV_W]);
                m_w = int'(cfg_wdata[DIV_W+2:DIV_W+1]);
                m_es = int'(cfg_wdata[DIV_W+3]);
                m_ddr = int'(cfg_wdata[DIV_W+4]);
                m_phase = 0; m_cnt = 0;
            end else if (m_div != 0) begin
                if (m_phase == 2) begin
                    if (stp == 0) begin m_phase = 0; m_cnt = 0; end
                end else if (m_cnt == m_div - 1) begin
                    m_phase = (m_phase == 1) ? 0 : (stp != 0 ? 2 : 1);
                    m_cnt = 0;
                end else begin
                    m_cnt++;
                end
            end
            m_idle = int'(bus_idle);
        end
        #2;
        if (rst_n && !done) begin
            bit byp, dde, fall, rise;
            int e_card, e_cmd, e_dat, e_onf;
            byp = (m_div == 0);
            dde = (m_ddr != 0) && (m_w != 0) && !byp;
            fall = !byp && m_phase == 1 && m_cnt == m_div - 1;
            rise = !byp && m_phase == 0 && m_cnt == m_div - 1 && (m_ps & m_idle) == 0;
            e_card = byp ? m_rund : int'(m_phase == 1);
            e_cmd = byp ? m_rund : int'(fall);
            e_dat = byp ? m_rund : int'(fall || (dde && rise));
            e_onf = (byp || dde) ? 1 : m_es;
            check("R1 R2 R6 card_clk", int'(card_clk), e_card);
            check("R7 cmd_stb", int'(cmd_stb), e_cmd);
            check("R8 R9 R10 dat_stb", int'(dat_stb), e_dat);
            check("R5 stb_on_fall", int'(stb_on_fall), e_onf);
            check("R3 R4 cfg_rdata", int'(cfg_rdata),
                  int'(pack(m_div, m_ps, m_w, m_es, m_ddr)));
        end
    end

    task automatic sample();
        @(posedge clk);
        #3;
    endtask

    task automatic wr(logic [CFG_W-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int prev, first_rise, second_rise, ncmd, ndat, nrise;
        // R11: reset state
        sample();
        check("R11 card_clk in reset", int'(card_clk), 0);
        check("R11 cmd_stb in reset", int'(cmd_stb), 0);
        check("R11 dat_stb in reset", int'(dat_stb), 0);
        check("R11 cfg in reset", int'(cfg_rdata), RST_DIV);
        @(negedge clk); rst_n = 1'b1;
        repeat (30) sample();

        // R1: divide by 3 gives a period of 6
        wr(pack(3, 0, 0, 0, 0));
        prev = 0; first_rise = -1; second_rise = -1;
        for (int i = 0; i < 40; i++) begin
            sample();
            if (card_clk && !prev) begin
                if (first_rise < 0) first_rise = i;
                else if (second_rise < 0) second_rise = i;
            end
            prev = int'(card_clk);
        end
        check("R1 period", second_rise - first_rise, 6);

        // R4: writes locked while busy
        @(negedge clk); cmd_busy = 1'b1;
        wr(pack(7, 1, 2, 1, 1));
        sample();
        check("R4 cmd_busy lock", int'(cfg_rdata), int'(pack(3, 0, 0, 0, 0)));
        @(negedge clk); cmd_busy = 1'b0; dat_busy = 1'b1;
        wr(pack(9, 0, 1, 0, 1));
        sample();
        check("R4 dat_busy lock", int'(cfg_rdata), int'(pack(3, 0, 0, 0, 0)));
        @(negedge clk); dat_busy = 1'b0;

        // R5: edge select in divided single-rate mode
        wr(pack(2, 0, 1, 1, 0));
        sample();
        check("R5 edge select", int'(stb_on_fall), 1);
        repeat (12) sample();

        // R2: bypass runs every cycle
        wr(pack(0, 0, 0, 0, 0));
        repeat (3) sample();
        nrise = 0;
        for (int i = 0; i < 10; i++) begin
            sample();
            nrise += int'(card_clk);
        end
        check("R2 bypass high phases", nrise, 10);

        // R6: power save parks the clock while idle
        @(negedge clk); bus_idle = 1'b1;
        wr(pack(2, 1, 0, 0, 0));
        repeat (8) sample();
        nrise = 0;
        for (int i = 0; i < 20; i++) begin
            sample();
            nrise += int'(card_clk);
        end
        check("R6 parked", nrise, 0);
        @(negedge clk); bus_idle = 1'b0;
        nrise = 0;
        for (int i = 0; i < 20; i++) begin
            sample();
            nrise += int'(card_clk);
        end
        check("R6 resumed", int'(nrise > 0), 1);

        // R6: bypass gating
        @(negedge clk); bus_idle = 1'b1;
        wr(pack(0, 1, 0, 0, 0));
        repeat (4) sample();
        nrise = 0;
        for (int i = 0; i < 10; i++) begin
            sample();
            nrise += int'(card_clk);
        end
        check("R6 bypass gated", nrise, 0);
        @(negedge clk); bus_idle = 1'b0;
        repeat (6) sample();

        // R8: double rate, 4-bit width
        wr(pack(2, 0, 1, 0, 1));
        ncmd = 0; ndat = 0;
        for (int i = 0; i < 40; i++) begin
            sample();
            ncmd += int'(cmd_stb);
            ndat += int'(dat_stb);
        end
        check("R8 dat twice cmd", int'(ndat - 2 * ncmd <= 1 && 2 * ncmd - ndat <= 1), 1);
        check("R8 cmd count", int'(ncmd >= 9), 1);

        // R9: double rate ignored at width 00
        wr(pack(2, 0, 0, 0, 1));
        ncmd = 0; ndat = 0;
        for (int i = 0; i < 40; i++) begin
            sample();
            ncmd += int'(cmd_stb);
            ndat += int'(dat_stb);
        end
        check("R9 dat equals cmd", ndat, ncmd);
        check("R9 launch edge", int'(stb_on_fall), 0);

        // R10: double rate with bypass stays single rate
        wr(pack(0, 0, 1, 0, 1));
        ncmd = 0; ndat = 0;
        for (int i = 0; i < 20; i++) begin
            sample();
            ncmd += int'(cmd_stb);
            ndat += int'(dat_stb);
        end
        check("R10 dat equals cmd", ndat, ncmd);
        check("R10 falling launch", int'(stb_on_fall), 1);

        wr(pack(5, 0, 2, 0, 1));
        repeat (40) sample();
        finish_run();
    end
endmodule